// File: doc/BRIEF.md
# Keyed-Lock Control Register Bank

The block is an 8-bit register bank reached through a plain word access port: an address, write data, a write strobe and a read strobe, with registered read data. It presents one identification word, three read-only status words built from live inputs, one command word holding two key-coded lock fields, one override word, and four configuration words. Software uses the override word to stand in for three external control pins once the input key has been set to the unlock code. Each effective control output then combines its pin level with its override bit through an AND or an OR. A per-input select bit in the last configuration word picks which.

A second key field freezes the four configuration words against further writes. A write or read to any address outside the defined set is blocked and latches an access-error flag. That flag becomes visible in bit 7 of the fault word on the following access, and stays set until software writes the clear bit of the command word. All words are registers with synchronous active-high reset, and the effective control outputs are registered one cycle after their inputs.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, the command word (08h) reads 09h, the override word (09h) reads 0Ch, the configuration words 0Ah..0Dh read 10h, 00h, 40h, 04h, the access-error flag is 0, and during reset `eff_out` is 3'b100.
- R2: A read or write to an address other than 00h..03h and 08h..0Dh changes no word, a read of it returns 00h, and it sets the access-error flag, seen in bit 7 of word 01h from the next access on.
- R3: A valid write to 08h with bit 7 set clears the access-error flag; bit 7 of 08h always reads 0.
- R4: The input key is bits 4:3 of 08h: the value 10b opens the override path, and any other value closes it.
- R5: The config key is bits 1:0 of 08h: while it holds 10b, writes to 0Ah..0Dh are dropped and raise no error; any other value allows them.
- R6: While the override path is closed, `eff_out` equals `pin_in` one cycle later, whatever the override word holds.
- R7: While open, for each input b (2 = driver-off, 1 = enable, 0 = phase), eff_out[b] = pin_in[b] AND r_b when select bit b of 0Dh is 1, and pin_in[b] OR r_b when it is 0, where r_2, r_1, r_0 are bits 3, 1, 0 of 09h.
- R8: Unavailable bits read 0 and ignore writes; the bits that can be written and read back are 08h: 1Bh, 09h: 0Fh, 0Ah: FFh, 0Bh: EFh, 0Ch: DFh, 0Dh: DFh.
- R9: Words 00h..03h ignore writes. 00h returns the `DEV_ID` parameter, 01h returns {error flag, flt_in[6:0]}, and 02h returns sts_in. 03h returns {pin_in[2], 2'b00, sts_in[4], 3'b000, olp_in}.
- R10: `acc_rdata` takes the addressed word's pre-write value one cycle after the edge that samples `acc_rd` and holds while `acc_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | 8 | Write data |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_rdata | output | 8 | Registered read data |
| flt_in | input | 7 | Live fault bits shown in word 01h |
| sts_in | input | 8 | Live status word shown in 02h; bit 4 is the active state |
| olp_in | input | 1 | Off-state comparator level shown in 03h bit 0 |
| pin_in | input | 3 | External control pins {driver-off, enable, phase} |
| eff_out | output | 3 | Effective control levels after merging |
| cfg_flat | output | 32 | Configuration words, word i at bits 8i+7..8i |

## Verification
The bench sweeps every address in the address space so that a decoder which misses an edge such as 04h, 07h, 0Eh or a wrapped high address will be caught. Such a decoder would either leave the error flag clear or return stale data. Every write value goes to every writable word, which exposes a wrong mask by showing a reserved bit as 1 or losing a real one. All 512 combinations of select, override and pin are checked with the path open, and again with it closed. That catches a swapped AND/OR sense, a wrong override bit position, or leakage of the override bits through a closed key. The key codes are tried at 10b against their neighbours. A lock that compared only one bit would open or freeze on the wrong code, and a frozen write that raised the error flag would show up in word 01h.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int DW      = 8;
  localparam int NCFG    = 4;
  localparam int NPIN    = 3;
  localparam int A_ID    = 0;
  localparam int A_FLT   = 1;
  localparam int A_STS   = 2;
  localparam int A_STS2  = 3;
  localparam int A_CMD   = 8;
  localparam int A_OVR   = 9;
  localparam int A_CFG0  = 10;
  localparam logic [1:0] KEY_CODE = 2'b10;
  localparam logic [1:0] KEY_RST  = 2'b01;
  localparam logic [DW-1:0] OVR_RST  = 8'h0C;
  localparam logic [DW-1:0] OVR_MASK = 8'h0F;

  function automatic logic [DW-1:0] cfg_mask(input int i);
    case (i)
      0:       return 8'hFF;
      1:       return 8'hEF;
      default: return 8'hDF;
    endcase
  endfunction

  function automatic logic [DW-1:0] cfg_rst(input int i);
    case (i)
      0:       return 8'h10;
      1:       return 8'h00;
      2:       return 8'h40;
      default: return 8'h04;
    endcase
  endfunction

  function automatic logic addr_ok(input int a);
    return (a <= A_STS2) || ((a >= A_CMD) && (a < A_CFG0 + NCFG));
  endfunction
endpackage

// File: rtl/ctl_lock_ctrl.sv
module ctl_lock_ctrl
  import ctl_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic       clr_d,
  input  logic [1:0] in_key_d,
  input  logic [1:0] cfg_key_d,
  output logic [1:0] in_key,
  output logic [1:0] cfg_key,
  output logic       ovr_open,
  output logic       cfg_shut,
  output logic       clr_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_key  <= KEY_RST;
      cfg_key <= KEY_RST;
    end else if (cmd_we) begin
      in_key  <= in_key_d;
      cfg_key <= cfg_key_d;
    end
  end

  assign ovr_open  = (in_key == KEY_CODE);
  assign cfg_shut  = (cfg_key == KEY_CODE);
  assign clr_pulse = cmd_we & clr_d;

  // R4
  in_key_close_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && in_key_d != KEY_CODE) |=> !ovr_open);
  // R4
  in_key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && in_key_d == KEY_CODE) |=> ovr_open);
endmodule

// File: rtl/ctl_cfg_store.sv
module ctl_cfg_store
  import ctl_regbank_pkg::*;
#(
  parameter int N_WORDS = NCFG,
  parameter int W       = DW,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [W-1:0]       wdata,
  input  logic               shut,
  output logic [N_WORDS*W-1:0] flat
);
  logic [W-1:0] words [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= cfg_rst(g);
      else if (we && !shut && (int'(idx) == g))
        words[g] <= wdata & cfg_mask(g);
    end
    assign flat[g*W +: W] = words[g];
  end

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    shut |=> $stable(flat));
endmodule

// File: rtl/ctl_pin_merge.sv
module ctl_pin_merge #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = 3'b100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open,
  input  logic [N-1:0] pins,
  input  logic [N-1:0] ovr,
  input  logic [N-1:0] sel_and,
  output logic [N-1:0] eff
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic comb_v;
    always_comb begin
      if (!open)
        comb_v = pins[b];
      else if (sel_and[b])
        comb_v = pins[b] & ovr[b];
      else
        comb_v = pins[b] | ovr[b];
    end
    always_ff @(posedge clk) begin
      if (rst) eff[b] <= RST_VAL[b];
      else     eff[b] <= comb_v;
    end
  end

  // R6
  closed_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !open |=> eff == $past(pins));
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [7:0] DEV_ID = 8'h3C,
  localparam int CIW = $clog2(NCFG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic              acc_wr,
  input  logic              acc_rd,
  output logic [7:0]        acc_rdata,
  input  logic [6:0]        flt_in,
  input  logic [7:0]        sts_in,
  input  logic              olp_in,
  input  logic [2:0]        pin_in,
  output logic [2:0]        eff_out,
  output logic [NCFG*8-1:0] cfg_flat
);
  int unsigned a_int;
  logic        a_ok, is_cmd, is_ovr, is_cfg;
  logic        acc_err;
  logic [1:0]  in_key, cfg_key;
  logic        ovr_open, cfg_shut, clr_pulse;
  logic [7:0]  ovr_q;
  logic [ADDR_W-1:0] cfg_off;
  logic [CIW-1:0]    cfg_idx;
  logic [7:0]  rd_word;
  logic [7:0]  cfg_w [NCFG];

  assign a_int   = int'(acc_addr);
  assign a_ok    = addr_ok(a_int);
  assign is_cmd  = (a_int == A_CMD);
  assign is_ovr  = (a_int == A_OVR);
  assign is_cfg  = (a_int >= A_CFG0) && (a_int < A_CFG0 + NCFG);
  assign cfg_off = acc_addr - ADDR_W'(A_CFG0);
  assign cfg_idx = cfg_off[CIW-1:0];

  ctl_lock_ctrl u_lock (
    .clk(clk), .rst(rst),
    .cmd_we(acc_wr && is_cmd),
    .clr_d(acc_wdata[7]),
    .in_key_d(acc_wdata[4:3]),
    .cfg_key_d(acc_wdata[1:0]),
    .in_key(in_key), .cfg_key(cfg_key),
    .ovr_open(ovr_open), .cfg_shut(cfg_shut),
    .clr_pulse(clr_pulse)
  );

  ctl_cfg_store #(.N_WORDS(NCFG), .W(8)) u_cfg (
    .clk(clk), .rst(rst),
    .we(acc_wr && is_cfg),
    .idx(cfg_idx),
    .wdata(acc_wdata),
    .shut(cfg_shut),
    .flat(cfg_flat)
  );

  for (genvar g = 0; g < NCFG; g++) begin : g_unpack
    assign cfg_w[g] = cfg_flat[g*8 +: 8];
  end

  ctl_pin_merge #(.N(NPIN), .RST_VAL(3'b100)) u_merge (
    .clk(clk), .rst(rst),
    .open(ovr_open),
    .pins(pin_in),
    .ovr({ovr_q[3], ovr_q[1], ovr_q[0]}),
    .sel_and(cfg_w[NCFG-1][2:0]),
    .eff(eff_out)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ovr_q <= OVR_RST;
    else if (acc_wr && is_ovr)
      ovr_q <= acc_wdata & OVR_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc_err <= 1'b0;
    else if ((acc_wr || acc_rd) && !a_ok)
      acc_err <= 1'b1;
    else if (clr_pulse)
      acc_err <= 1'b0;
  end

  always_comb begin
    rd_word = 8'h00;
    if (a_int == A_ID)        rd_word = DEV_ID;
    else if (a_int == A_FLT)  rd_word = {acc_err, flt_in};
    else if (a_int == A_STS)  rd_word = sts_in;
    else if (a_int == A_STS2) rd_word = {pin_in[2], 2'b00, sts_in[4], 3'b000, olp_in};
    else if (is_cmd)          rd_word = {3'b000, in_key, 1'b0, cfg_key};
    else if (is_ovr)          rd_word = ovr_q;
    else if (is_cfg)          rd_word = cfg_w[cfg_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)         acc_rdata <= 8'h00;
    else if (acc_rd) acc_rdata <= rd_word;
  end

  // R2
  bad_addr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && !a_ok) |=> acc_err);
  // R2
  bad_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !a_ok) |=> acc_rdata == 8'h00);
  // R8
  cmd_spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && is_cmd) |=> (acc_rdata & 8'hE4) == 8'h00);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(acc_rdata));
endmodule

// File: tb/sim_ctl_regbank.sv
`timescale 1ns/1ps
module sim_ctl_regbank;
  localparam int AW = 6;
  localparam logic [7:0] ID = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic acc_wr = 1'b0, acc_rd = 1'b0;
  logic [7:0] acc_rdata;
  logic [6:0] flt_in = 7'h00;
  logic [7:0] sts_in = 8'h00;
  logic olp_in = 1'b0;
  logic [2:0] pin_in = 3'b000;
  logic [2:0] eff_out;
  logic [31:0] cfg_flat;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] cmd_m, ovr_m, rv;
  logic [7:0] cfg_m [4];
  logic err_m;
  logic [7:0] msk [4] = '{8'hFF, 8'hEF, 8'hDF, 8'hDF};

  always #5 clk = ~clk;

  ctl_regbank #(.ADDR_W(AW), .DEV_ID(ID)) u0 (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_rdata(acc_rdata),
    .flt_in(flt_in), .sts_in(sts_in), .olp_in(olp_in),
    .pin_in(pin_in), .eff_out(eff_out), .cfg_flat(cfg_flat));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic bit ok_addr(input int a);
    return (a <= 3) || (a >= 8 && a <= 13);
  endfunction

  task automatic model_wr(input int a, input logic [7:0] d);
    if (!ok_addr(a)) err_m = 1'b1;
    else if (a == 8) begin
      cmd_m = d & 8'h1B;
      if (d[7]) err_m = 1'b0;
    end else if (a == 9) ovr_m = d & 8'h0F;
    else if (a >= 10 && cmd_m[1:0] != 2'b10) cfg_m[a-10] = d & msk[a-10];
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    acc_addr = AW'(a); acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    acc_addr = AW'(a); acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
    if (!ok_addr(a)) err_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_word(input int a);
    case (a)
      0: return ID;
      1: return {err_m, flt_in};
      2: return sts_in;
      3: return {pin_in[2], 2'b00, sts_in[4], 3'b000, olp_in};
      8: return cmd_m;
      9: return ovr_m;
      10, 11, 12, 13: return cfg_m[a-10];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] exp_eff(input logic [2:0] p);
    logic [2:0] r, s, e;
    r = {ovr_m[3], ovr_m[1], ovr_m[0]};
    s = cfg_m[3][2:0];
    for (int b = 0; b < 3; b++)
      e[b] = (cmd_m[4:3] != 2'b10) ? p[b] : (s[b] ? (p[b] & r[b]) : (p[b] | r[b]));
    return e;
  endfunction

  task automatic chk_all(input string tag);
    for (int a = 8; a <= 13; a++) begin
      logic [7:0] v;
      rd(a, v);
      chk(tag, v, exp_word(a));
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cmd_m = 8'h09; ovr_m = 8'h0C; err_m = 1'b0;
    cfg_m[0] = 8'h10; cfg_m[1] = 8'h00; cfg_m[2] = 8'h40; cfg_m[3] = 8'h04;
    repeat (3) @(negedge clk);
    chk("R1 eff_out in reset", {5'b0, eff_out}, 8'h04);
    rst = 1'b0;
    pin_in = 3'b011;
    @(negedge clk);
    chk("R1/R6 eff after reset", {5'b0, eff_out}, 8'h03);
    chk_all("R1 reset word");
    rd(1, rv); chk("R1 error flag reset", rv, {1'b0, flt_in});

    // R9: read-only words, two patterns, writes ignored
    for (int pat = 0; pat < 2; pat++) begin
      flt_in = pat ? 7'h2A : 7'h55;
      sts_in = pat ? 8'h59 : 8'hB6;
      olp_in = pat[0];
      pin_in = pat ? 3'b100 : 3'b011;
      for (int a = 0; a <= 3; a++) begin
        rd(a, rv); chk("R9 ro read", rv, exp_word(a));
        wr(a, 8'hFF ^ rv);
        rd(a, rv); chk("R9 ro write ignored", rv, exp_word(a));
      end
    end

    // R8: every value into every writable word
    for (int a = 8; a <= 13; a++) begin
      for (int d = 0; d < 256; d++) begin
        wr(a, 8'(d));
        if (a == 8 && cmd_m[1:0] == 2'b10 && d[7:5] != 0) wr(8, 8'h01);
        rd(a, rv); chk("R8 mask readback", rv, exp_word(a));
      end
    end
    wr(8, 8'h09);
    rd(8, rv); chk("R3 clear bit reads 0", rv, 8'h09);

    // R2/R3: full address sweep
    for (int a = 0; a < (1 << AW); a++) begin
      rd(a, rv); chk("R2 address sweep read", rv, exp_word(a));
      rd(1, rv); chk("R2 error flag after access", rv, {err_m, flt_in});
      wr(8, 8'h89);
      rd(1, rv); chk("R3 error cleared", rv, {1'b0, flt_in});
    end
    for (int a = 14; a < (1 << AW); a += 9) begin
      wr(a, 8'hA5);
      chk_all("R2 invalid write no effect");
      rd(1, rv); chk("R2 invalid write flags", rv, {1'b1, flt_in});
      wr(8, 8'h89);
    end

    // R5: config key codes
    for (int k = 0; k < 4; k++) begin
      wr(8, 8'(k));
      for (int a = 10; a <= 13; a++) wr(a, 8'(8'h5A + a + k * 16));
      chk_all("R5 config key");
      rd(1, rv); chk("R5 frozen write no error", rv, {1'b0, flt_in});
    end
    wr(8, 8'h01);

    // R4/R6/R7: merge sweep under each input key code
    for (int k = 0; k < 4; k++) begin
      wr(8, 8'(k * 8 + 1));
      for (int s = 0; s < 8; s++) begin
        wr(13, (cfg_m[3] & 8'hF8) | 8'(s));
        for (int o = 0; o < 8; o++) begin
          wr(9, {4'b0, o[2], 1'b1, o[1], o[0]});
          for (int p = 0; p < 8; p++) begin
            @(negedge clk) pin_in = 3'(p);
            @(negedge clk);
            chk((k == 2) ? "R7 merged output" : "R4/R6 closed passthru",
                {5'b0, eff_out}, {5'b0, exp_eff(3'(p))});
          end
        end
      end
    end

    // R10: read data holds while read strobe low
    rd(12, rv);
    acc_addr = AW'(0);
    repeat (4) @(negedge clk);
    chk("R10 rdata hold", acc_rdata, cfg_m[2]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule